// File: doc/BRIEF.md
# 32-Pin GPIO Controller with Edge Interrupts

This block is a 32-pin general-purpose I/O controller that sits behind a plain 32-bit register bus with read and write strobes, an address and data. Software uses it to choose each pin's direction, to drive output values, and to read a combined data view. That view shows the output latch for driven pins and the synchronised pad level for input pins.

Each pad input goes through a two-flop synchroniser and then an edge detector. Every edge that matches the pin's sense setting sets a sticky event bit. An event bit is cleared by writing 1 to it. A mask register selects which events drive the single interrupt output.

The parameter `TWO_BIT_SENSE` picks the sense encoding. With the value 0, each pin has one sense bit. With the value 1, each pin has a two-bit code, and these codes are spread over two sense registers. Per-pin registers are numbered from the most significant bit, so pin n sits at bit 31 − n.

Top module: `gpio_bank32`

## Requirements
- R1: After reset every register reads 0. `pad_oe` is 0 and `irq` is 0.
- R2: Direction register (offset 0x00): bit = 1 makes the pin an output. `pad_oe` equals the register from the edge after the write onward.
- R3: Writing offset 0x08 loads the output latch, and `pad_out` shows it after the write edge. A read of 0x08 returns the latch bits where the pin is an output, and the synchronised pad bits where it is an input.
- R4: Pin n occupies bit 31 − n of every per-pin register and pad vector. Pin 0 is the MSB.
- R5: Event register (offset 0x0C): writing 1 to a bit clears it. Writing 0 to a bit leaves it unchanged.
- R6: If a clearing write and a new qualifying edge hit the same event bit in the same cycle, the bit stays set.
- R7: Mask register (offset 0x10): bit = 1 enables that pin. `irq` is the OR over all bits of (event AND mask).
- R8: With `TWO_BIT_SENSE`=0, sense bit = 1 (offset 0x14) flags only falling edges, and sense bit = 0 flags both rising and falling edges.
- R9: With `TWO_BIT_SENSE`=1, pins 0–15 take their code from offset 0x14 at bits (15−n)·2+1:(15−n)·2. Pins 16–31 take theirs from offset 0x18 at bits (15−(n−16))·2+1:(15−(n−16))·2. Code 2'b10 means falling only, 2'b01 means rising only, and 2'b00 or 2'b11 means both edges.
- R10: Offset 0x04 is plain read/write storage. Offset 0x18 reads 0 and ignores writes when `TWO_BIT_SENSE`=0. Any unmapped offset reads 0.
- R11: A pad change latches its event on the third rising edge after the change. `irq` rises right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is registered |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, captured on the edge where bus_rd is high |
| pad_in | input | 32 | Pad levels, bit 31 − n is pin n |
| pad_out | output | 32 | Output latch |
| pad_oe | output | 32 | Output enables (direction register) |
| irq | output | 1 | Combined interrupt |

## Verification
The outputs have different delays:
- A register write shows on `pad_oe` and `pad_out` at the edge that samples the strobe.
- A read captures the register's value from just before that same edge, and returns it one edge later.
- A pad change reaches the data view after two edges, and reaches the event register and `irq` after three edges.

The bench drives stimulus on falling edges and samples on the next falling edge. It counts edges explicitly at each point. To check R11, it confirms that `irq` is still low after the first and second edges and high after the third. For R6, the clearing write is timed to coincide with that third edge.

// File: rtl/gpio_bank32.sv
module gpio_bank32 #(
  parameter int NPIN          = 32,
  parameter int AW            = 8,
  parameter bit TWO_BIT_SENSE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam int HALF = NPIN / 2;
  localparam logic [AW-1:0] A_DIR  = AW'(8'h00);
  localparam logic [AW-1:0] A_ODR  = AW'(8'h04);
  localparam logic [AW-1:0] A_DAT  = AW'(8'h08);
  localparam logic [AW-1:0] A_EV   = AW'(8'h0C);
  localparam logic [AW-1:0] A_MSK  = AW'(8'h10);
  localparam logic [AW-1:0] A_SNSA = AW'(8'h14);
  localparam logic [AW-1:0] A_SNSB = AW'(8'h18);

  logic [NPIN-1:0] dir_q, odr_q, dat_q, ev_q, msk_q, sns_a_q, sns_b_q;
  logic [NPIN-1:0] s1_q, s2_q, s3_q;
  logic [NPIN-1:0] rise, fall, hit, rd_mux;
  logic            wr_ev;

  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;
  assign wr_ev = bus_wr && (bus_addr == A_EV);

  for (genvar b = 0; b < NPIN; b++) begin : g_sense
    if (TWO_BIT_SENSE) begin : g_two
      logic [1:0] code;
      if (b >= HALF) begin : g_hi
        assign code = sns_a_q[(b-HALF)*2 +: 2];
      end else begin : g_lo
        assign code = sns_b_q[b*2 +: 2];
      end
      always_comb begin
        case (code)
          2'b10:   hit[b] = fall[b];
          2'b01:   hit[b] = rise[b];
          default: hit[b] = rise[b] | fall[b];
        endcase
      end
    end else begin : g_one
      assign hit[b] = fall[b] | (~sns_a_q[b] & rise[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      odr_q   <= '0;
      dat_q   <= '0;
      msk_q   <= '0;
      sns_a_q <= '0;
      sns_b_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DIR:  dir_q   <= bus_wdata;
        A_ODR:  odr_q   <= bus_wdata;
        A_DAT:  dat_q   <= bus_wdata;
        A_MSK:  msk_q   <= bus_wdata;
        A_SNSA: sns_a_q <= bus_wdata;
        A_SNSB: if (TWO_BIT_SENSE) sns_b_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (ev_q & ~(wr_ev ? bus_wdata : '0)) | hit;
  end

  always_comb begin
    case (bus_addr)
      A_DIR:   rd_mux = dir_q;
      A_ODR:   rd_mux = odr_q;
      A_DAT:   rd_mux = (dat_q & dir_q) | (s2_q & ~dir_q);
      A_EV:    rd_mux = ev_q;
      A_MSK:   rd_mux = msk_q;
      A_SNSA:  rd_mux = sns_a_q;
      A_SNSB:  rd_mux = TWO_BIT_SENSE ? sns_b_q : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign pad_out = dat_q;
  assign pad_oe  = dir_q;
  assign irq     = |(ev_q & msk_q);
endmodule

module gpio_bank32_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] ev,
  input logic [NPIN-1:0] msk,
  input logic            irq
);
  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h00)) |=> (pad_oe == $past(bus_wdata))); // R2
  AST_OUT_TRACKS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(8'h08)) |=> (pad_out == $past(bus_wdata))); // R3
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(8'h0C)) |=> ((ev & $past(ev)) == $past(ev))); // R5
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == '0) |-> !irq); // R7
endmodule

bind gpio_bank32 gpio_bank32_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .ev(ev_q), .msk(msk_q), .irq(irq)
);

// File: tb/gpio_bank32_bench.sv
module gpio_bank32_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1, pad0 = '0, pad1 = '0;
  logic [31:0] out0, out1, oe0, oe1;
  logic        irq0, irq1;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gpio_bank32 #(.TWO_BIT_SENSE(1'b0)) u_gpio_bank32 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pad_in(pad0), .pad_out(out0),
    .pad_oe(oe0), .irq(irq0));

  gpio_bank32 #(.TWO_BIT_SENSE(1'b1)) u_gpio_bank32_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pad_in(pad1), .pad_out(out1),
    .pad_oe(oe1), .irq(irq1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d0 = rdata0; d1 = rdata1;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    for (int i = 0; i < 7; i++) begin
      rd(8'(i*4), a, b);
      check("R1 reg", a, 32'h0);
      check("R1 reg two-bit", b, 32'h0);
    end
    check("R1 pad_oe", oe0, 32'h0);
    check("R1 irq", {31'h0, irq0 | irq1}, 32'h0);
  endtask

  task automatic t_dir_data();
    logic [31:0] a, b;
    wr(8'h00, 32'hF0F0_0000);
    check("R2 pad_oe", oe0, 32'hF0F0_0000);
    wr(8'h08, 32'hAAAA_5555);
    check("R3 pad_out", out0, 32'hAAAA_5555);
    @(negedge clk); pad0 = 32'h0FFF_FF00;
    settle();
    rd(8'h08, a, b);
    check("R3 data view", a, (32'hAAAA_5555 & 32'hF0F0_0000) | (32'h0FFF_FF00 & 32'h0F0F_FFFF));
    wr(8'h04, 32'h1234_5678);
    rd(8'h04, a, b);
    check("R10 storage reg", a, 32'h1234_5678);
    wr(8'h18, 32'hDEAD_BEEF);
    rd(8'h18, a, b);
    check("R10 second sense absent in one-bit mode", a, 32'h0);
    check("R9 second sense present", b, 32'hDEAD_BEEF);
    rd(8'h1C, a, b);
    check("R10 unmapped", a, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, a, b);
    check("R5 clear all", a, 32'h0);
    @(negedge clk); pad0 = '0;
    settle();
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_latency_irq();
    logic [31:0] a, b;
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h8000_0000);
    @(negedge clk); pad0 = 32'h8000_0000;
    @(negedge clk); check("R11 irq after 1 edge", {31'h0, irq0}, 32'h0);
    @(negedge clk); check("R11 irq after 2 edges", {31'h0, irq0}, 32'h0);
    @(negedge clk); check("R11 irq after 3 edges", {31'h0, irq0}, 32'h1);
    rd(8'h0C, a, b);
    check("R4 pin0 is MSB", a, 32'h8000_0000);
    wr(8'h0C, 32'h0);
    rd(8'h0C, a, b);
    check("R5 write 0 keeps", a, 32'h8000_0000);
    wr(8'h0C, 32'h8000_0000);
    check("R5 write 1 clears irq", {31'h0, irq0}, 32'h0);
    wr(8'h10, 32'h0000_0001);
    @(negedge clk); pad0 = 32'h8000_0000 | 32'h0000_0001;
    settle();
    check("R7 masked pin31 drives irq", {31'h0, irq0}, 32'h1);
    wr(8'h10, 32'h7FFF_FFFE);
    check("R7 other bits masked", {31'h0, irq0}, 32'h0);
    wr(8'h10, 32'h0);
    @(negedge clk); pad0 = '0;
    settle();
    wr(8'h0C, 32'hFFFF_FFFF);
  endtask

  task automatic t_single_sense();
    logic [31:0] a, b;
    wr(8'h14, 32'h0000_0001);
    @(negedge clk); pad0 = 32'h0000_0003;
    settle();
    rd(8'h0C, a, b);
    check("R8 rise: bit0 fall-only skips, bit1 both flags", a, 32'h0000_0002);
    wr(8'h0C, 32'hFFFF_FFFF);
    @(negedge clk); pad0 = '0;
    settle();
    rd(8'h0C, a, b);
    check("R8 fall flags both bits", a, 32'h0000_0003);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0);
  endtask

  task automatic t_two_bit();
    logic [31:0] a, b;
    wr(8'h14, 32'h4000_0003);
    wr(8'h18, 32'h0000_0002);
    rd(8'h14, a, b);
    check("R9 first sense readback", b, 32'h4000_0003);
    @(negedge clk); pad1 = 32'h8001_8001;
    settle();
    rd(8'h0C, a, b);
    check("R9 rising", b, 32'h8001_8000);
    wr(8'h0C, 32'hFFFF_FFFF);
    @(negedge clk); pad1 = '0;
    settle();
    rd(8'h0C, a, b);
    check("R9 falling", b, 32'h0001_8001);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0);
    wr(8'h18, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] a, b;
    wr(8'h0C, 32'hFFFF_FFFF);
    @(negedge clk); pad0 = 32'h0000_0020;
    settle();
    @(negedge clk); pad0 = '0;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(8'h0C, a, b);
    check("R6 new edge wins over clear", a, 32'h0000_0020);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, a, b);
    check("R6 later clear works", a, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir_data();
    t_latency_irq();
    t_single_sense();
    t_two_bit();
    t_collision();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule